// File: doc/BRIEF.md
# Interleaved Two-View Bit-Flipping Decoder Controller

This block decodes a hard-decision concatenated codeword made of a message, a parity set computed on that message in natural order, and a second parity set computed on an interleaved copy of the message. The block has one combinational bit-flipping decoder. A small controller time-shares that decoder between the two views of the codeword. Two register banks keep the current estimate of each view. A super iteration runs one local iteration on the natural view, then one on the interleaved view, then merges the two banks.

The interleaved view is never stored in permuted order. Both banks keep the message in natural order. On the way into the decoder, the message of the second bank passes through an interleaver. On the way back, the result passes through the matching de-interleaver. A decode starts with a one-cycle start pulse carrying the received word. It ends with a one-cycle done pulse that reports success or failure, the decoded message and the number of super iterations completed.

Top module: `pcgc_bf_decoder`

## Requirements
- R1: After reset, done and success are 0, superIters is 0 and message is 0.
- R2: A super iteration takes exactly three cycles, in a fixed order: the natural-view local iteration, then the interleaved-view local iteration, then the merge. After a start is sampled, a view that passes its syndrome check in step s (1 or 2) of super iteration n (counted from 0) raises done on clock edge 3n+s.
- R3: rxWord holds the message in bits [K-1:0], parity set A in [2K-1:K] and parity set B in [3K-1:2K]. The interleaved message is u[i] = m[(ILV_MULT*i + ILV_ADD) mod K]. Parity set B is computed on u. The message results of the interleaved view are de-interleaved before they are written back.
- R4: Check j of a view with message x and parity p is x[j] ^ x[(j+TAP1) mod K] ^ x[(j+TAP2) mod K] ^ p[j]. Each message bit therefore sits in three checks and each parity bit in one. A view is valid when all K checks are 0.
- R5: A local iteration flips every message bit that has at least 2 of its 3 checks failing. It flips a parity bit when its check fails and none of the message bits in that check is being flipped.
- R6: The merge sets every message bit in both banks to the majority of the received bit, the first-bank bit and the second-bank bit. Each parity set keeps the value held in its own bank.
- R7: A view found valid at the start of its step ends the decode with success 1. The message comes from that view's bank, and superIters equals the number of merges completed so far.
- R8: When the merge of super iteration MAX_SUPER completes without success, the decode ends with success 0, superIters equal to MAX_SUPER and message equal to the merged estimate.
- R9: done is high for exactly one cycle. success, message and superIters hold their values until the next decode ends.
- R10: A start pulse that arrives while a decode is running is ignored, and the running decode completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle pulse that loads rxWord and starts a decode |
| rxWord | input | 3*MSG_W | Received hard decisions: parity B, parity A, message |
| done | output | 1 | One-cycle completion pulse |
| success | output | 1 | 1 when one view reached a zero syndrome |
| message | output | MSG_W | Decoded message |
| superIters | output | ITER_W | Super iterations completed at termination |

## Verification
The bench injects single errors into each of the three codeword fields and checks which view terminates the decode, and on which cycle. If a design read parity B against the wrong interleaver, it would reject a clean interleaved view. That decode would then finish late or never. A single message error has to be repaired in both banks and merged. A broken de-interleaver would corrupt the second bank, and the majority would then keep the error. A combined message-plus-parity error makes the natural view miscorrect its parity, so only the interleaved view can end that decode. A second instance with a limit of one super iteration exposes an off-by-one in the termination count, or a message that is not taken from the merge. A start pulse sent mid-decode catches a controller that restarts.

// File: rtl/pcgc_pkg.sv
package pcgc_pkg;

  typedef enum logic [1:0] {
    SRC_NAT   = 2'd0,
    SRC_PERM  = 2'd1,
    SRC_MERGE = 2'd2
  } out_src_e;

  typedef struct packed {
    logic     load;
    logic     selPerm;
    logic     wrNat;
    logic     wrPerm;
    logic     wrMerge;
    logic     latchOut;
    out_src_e outSrc;
  } strobe_t;

  // Forward map of the interleaver: position i of the permuted view
  function automatic int permSrc(input int i, input int mult, input int add, input int k);
    return (mult * i + add) % k;
  endfunction

  // Inverse map, found by search (evaluated at elaboration)
  function automatic int permInv(input int i, input int mult, input int add, input int k);
    int res;
    res = 0;
    for (int n = 0; n < k; n++) begin
      if (((mult * n + add) % k) == i) res = n;
    end
    return res;
  endfunction

endpackage

// File: rtl/pcgc_flip_core.sv
module pcgc_flip_core #(
  parameter int K    = 16,
  parameter int TAP1 = 1,
  parameter int TAP2 = 3
) (
  input  logic [K-1:0] msgIn,
  input  logic [K-1:0] parIn,
  output logic [K-1:0] msgOut,
  output logic [K-1:0] parOut,
  output logic         synZero
);

  localparam int COL_W   = 3;
  localparam int FLIP_AT = COL_W / 2 + 1;

  logic [K-1:0] syn;
  logic [K-1:0] flipMsg;
  logic [K-1:0] flipPar;

  generate
    for (genvar j = 0; j < K; j++) begin : g_check
      localparam int A = (j + TAP1) % K;
      localparam int B = (j + TAP2) % K;
      assign syn[j] = msgIn[j] ^ msgIn[A] ^ msgIn[B] ^ parIn[j];
    end

    for (genvar i = 0; i < K; i++) begin : g_msgbit
      localparam int C1 = (i - TAP1 + K) % K;
      localparam int C2 = (i - TAP2 + K) % K;
      logic [1:0] failCnt;
      assign failCnt    = 2'(syn[i]) + 2'(syn[C1]) + 2'(syn[C2]);
      assign flipMsg[i] = (failCnt >= 2'(FLIP_AT));
    end

    for (genvar j = 0; j < K; j++) begin : g_parbit
      localparam int A = (j + TAP1) % K;
      localparam int B = (j + TAP2) % K;
      assign flipPar[j] = syn[j] & ~(flipMsg[j] | flipMsg[A] | flipMsg[B]);
    end
  endgenerate

  assign msgOut  = msgIn ^ flipMsg;
  assign parOut  = parIn ^ flipPar;
  assign synZero = (syn == '0);

endmodule

// File: rtl/pcgc_datapath.sv
module pcgc_datapath
  import pcgc_pkg::*;
#(
  parameter int K        = 16,
  parameter int TAP1     = 1,
  parameter int TAP2     = 3,
  parameter int ILV_MULT = 5,
  parameter int ILV_ADD  = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3*K-1:0] rxWord,
  input  strobe_t      strb,
  output logic         synZero,
  output logic [K-1:0] decodedMsg
);

  logic [K-1:0] chanMsg;
  logic [K-1:0] natMsg, natPar;
  logic [K-1:0] permMsg, permPar;
  logic [K-1:0] ilvMsg, deilvMsg;
  logic [K-1:0] coreMsgIn, coreParIn, coreMsgOut, coreParOut;
  logic [K-1:0] mergedMsg;

  generate
    for (genvar i = 0; i < K; i++) begin : g_ilv
      localparam int SRC = permSrc(i, ILV_MULT, ILV_ADD, K);
      localparam int INV = permInv(i, ILV_MULT, ILV_ADD, K);
      assign ilvMsg[i]   = permMsg[SRC];
      assign deilvMsg[i] = coreMsgOut[INV];
    end
  endgenerate

  always_comb begin
    if (strb.selPerm) begin
      coreMsgIn = ilvMsg;
      coreParIn = permPar;
    end else begin
      coreMsgIn = natMsg;
      coreParIn = natPar;
    end
  end

  pcgc_flip_core #(.K(K), .TAP1(TAP1), .TAP2(TAP2)) u_core (
    .msgIn  (coreMsgIn),
    .parIn  (coreParIn),
    .msgOut (coreMsgOut),
    .parOut (coreParOut),
    .synZero(synZero)
  );

  assign mergedMsg = (chanMsg & natMsg) | (chanMsg & permMsg) | (natMsg & permMsg);

  always_ff @(posedge clk) begin
    if (rst) begin
      chanMsg <= '0;
      natMsg  <= '0;
      natPar  <= '0;
      permMsg <= '0;
      permPar <= '0;
    end else if (strb.load) begin
      chanMsg <= rxWord[K-1:0];
      natMsg  <= rxWord[K-1:0];
      natPar  <= rxWord[2*K-1:K];
      permMsg <= rxWord[K-1:0];
      permPar <= rxWord[3*K-1:2*K];
    end else if (strb.wrNat) begin
      natMsg <= coreMsgOut;
      natPar <= coreParOut;
    end else if (strb.wrPerm) begin
      permMsg <= deilvMsg;
      permPar <= coreParOut;
    end else if (strb.wrMerge) begin
      natMsg  <= mergedMsg;
      permMsg <= mergedMsg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      decodedMsg <= '0;
    end else if (strb.latchOut) begin
      case (strb.outSrc)
        SRC_NAT:  decodedMsg <= natMsg;
        SRC_PERM: decodedMsg <= permMsg;
        default:  decodedMsg <= mergedMsg;
      endcase
    end
  end

  AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strb.load |=> $stable(chanMsg)) else $error("channel copy changed"); // R6
  AST_PARA_HOLD: assert property (@(posedge clk) disable iff (rst)
    strb.wrPerm |=> $stable(natPar)) else $error("parity A touched in step 2"); // R6
  AST_PARB_HOLD: assert property (@(posedge clk) disable iff (rst)
    strb.wrNat |=> $stable(permPar)) else $error("parity B touched in step 1"); // R6
  AST_MERGE_SYNC: assert property (@(posedge clk) disable iff (rst)
    strb.wrMerge |=> (natMsg == permMsg)) else $error("banks differ after merge"); // R6

endmodule

// File: rtl/pcgc_ctrl.sv
module pcgc_ctrl
  import pcgc_pkg::*;
#(
  parameter int MAX_SUPER = 8,
  parameter int ITER_W    = $clog2(MAX_SUPER + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              synZero,
  output strobe_t           strb,
  output logic              done,
  output logic              success,
  output logic [ITER_W-1:0] superIters
);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_NAT   = 2'd1,
    ST_PERM  = 2'd2,
    ST_MERGE = 2'd3
  } state_e;

  state_e            state, stateNext;
  logic [ITER_W-1:0] iterCnt;
  logic              lastMerge;
  logic              finish, finishOk;

  assign lastMerge = (iterCnt == ITER_W'(MAX_SUPER - 1));

  always_comb begin
    strb      = '0;
    stateNext = state;
    finish    = 1'b0;
    finishOk  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          stateNext = ST_NAT;
        end
      end
      ST_NAT: begin
        if (synZero) begin
          strb.latchOut = 1'b1;
          strb.outSrc   = SRC_NAT;
          finish        = 1'b1;
          finishOk      = 1'b1;
          stateNext     = ST_IDLE;
        end else begin
          strb.wrNat = 1'b1;
          stateNext  = ST_PERM;
        end
      end
      ST_PERM: begin
        strb.selPerm = 1'b1;
        if (synZero) begin
          strb.latchOut = 1'b1;
          strb.outSrc   = SRC_PERM;
          finish        = 1'b1;
          finishOk      = 1'b1;
          stateNext     = ST_IDLE;
        end else begin
          strb.wrPerm = 1'b1;
          stateNext   = ST_MERGE;
        end
      end
      ST_MERGE: begin
        strb.wrMerge = 1'b1;
        if (lastMerge) begin
          strb.latchOut = 1'b1;
          strb.outSrc   = SRC_MERGE;
          finish        = 1'b1;
          stateNext     = ST_IDLE;
        end else begin
          stateNext = ST_NAT;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      iterCnt    <= '0;
      done       <= 1'b0;
      success    <= 1'b0;
      superIters <= '0;
    end else begin
      state <= stateNext;
      done  <= finish;
      if (strb.load) begin
        iterCnt <= '0;
      end else if (strb.wrMerge) begin
        iterCnt <= iterCnt + 1'b1;
      end
      if (finish) begin
        success    <= finishOk;
        superIters <= strb.wrMerge ? iterCnt + 1'b1 : iterCnt;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle"); // R9
  AST_PERM_AFTER_NAT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PERM) |-> ($past(state) == ST_NAT)) else $error("step order broken"); // R2
  AST_MERGE_AFTER_PERM: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MERGE) |-> ($past(state) == ST_PERM)) else $error("merge out of order"); // R2
  AST_OK_NEEDS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done && success) |-> $past(synZero)) else $error("success without zero syndrome"); // R7
  AST_FAIL_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (done && !success) |-> (superIters == ITER_W'(MAX_SUPER))) else $error("early give-up"); // R8
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
    (start && state != ST_IDLE) |-> !strb.load) else $error("reload while busy"); // R10

endmodule

// File: rtl/pcgc_bf_decoder.sv
module pcgc_bf_decoder
  import pcgc_pkg::*;
#(
  parameter int MSG_W     = 16,
  parameter int TAP1      = 1,
  parameter int TAP2      = 3,
  parameter int ILV_MULT  = 5,
  parameter int ILV_ADD   = 3,
  parameter int MAX_SUPER = 8,
  parameter int ITER_W    = $clog2(MAX_SUPER + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [3*MSG_W-1:0] rxWord,
  output logic               done,
  output logic               success,
  output logic [MSG_W-1:0]   message,
  output logic [ITER_W-1:0]  superIters
);

  strobe_t strb;
  logic    synZero;

  pcgc_ctrl #(.MAX_SUPER(MAX_SUPER), .ITER_W(ITER_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .synZero   (synZero),
    .strb      (strb),
    .done      (done),
    .success   (success),
    .superIters(superIters)
  );

  pcgc_datapath #(
    .K(MSG_W), .TAP1(TAP1), .TAP2(TAP2), .ILV_MULT(ILV_MULT), .ILV_ADD(ILV_ADD)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .rxWord    (rxWord),
    .strb      (strb),
    .synZero   (synZero),
    .decodedMsg(message)
  );

endmodule

// File: tb/tb_pcgc_bf_decoder.sv
module tb_pcgc_bf_decoder;

  localparam int K = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [3*K-1:0] rxWord = '0;
  logic          done, success;
  logic [K-1:0]  message;
  logic [3:0]    superIters;

  logic          startS = 1'b0;
  logic [3*K-1:0] rxWordS = '0;
  logic          doneS, successS;
  logic [K-1:0]  messageS;
  logic [0:0]    superItersS;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pcgc_bf_decoder dut (
    .clk(clk), .rst(rst), .start(start), .rxWord(rxWord),
    .done(done), .success(success), .message(message), .superIters(superIters)
  );

  pcgc_bf_decoder #(.MAX_SUPER(1)) dutShort (
    .clk(clk), .rst(rst), .start(startS), .rxWord(rxWordS),
    .done(doneS), .success(successS), .message(messageS), .superIters(superItersS)
  );

  function automatic logic [K-1:0] parityOf(input logic [K-1:0] m);
    logic [K-1:0] p;
    for (int j = 0; j < K; j++) p[j] = m[j] ^ m[(j + 1) % K] ^ m[(j + 3) % K];
    return p;
  endfunction

  function automatic logic [K-1:0] interleave(input logic [K-1:0] m);
    logic [K-1:0] u;
    for (int i = 0; i < K; i++) u[i] = m[(5 * i + 3) % K];
    return u;
  endfunction

  function automatic logic [3*K-1:0] encode(input logic [K-1:0] m);
    return {parityOf(interleave(m)), parityOf(m), m};
  endfunction

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive a start, count edges after the sampling edge until done
  task automatic runDecode(input logic [3*K-1:0] word, input int busyPulseAt, output int lat);
    lat = 0;
    @(negedge clk);
    rxWord = word;
    start  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    while (lat < 200) begin
      @(posedge clk);
      #1;
      lat++;
      if (done) break;
      if (lat == busyPulseAt) begin
        @(negedge clk);
        rxWord = encode(16'h0F0F);
        start  = 1'b1;
        @(posedge clk);
        #1;
        lat++;
        if (done) break;
        @(negedge clk);
        start = 1'b0;
      end
    end
  endtask

  task automatic expectResult(input string req, input logic [3*K-1:0] word, input int busyAt,
                              input int expLat, input bit expOk, input int expIters,
                              input logic [K-1:0] expMsg);
    int lat;
    logic [K-1:0] heldMsg;
    runDecode(word, busyAt, lat);
    check({req, " latency"}, lat == expLat, lat, expLat);
    check({req, " success"}, success == expOk, success, expOk);
    check({req, " iterations"}, superIters == 4'(expIters), superIters, expIters);
    check({req, " message"}, message == expMsg, message, expMsg);
    heldMsg = message;
    @(posedge clk);
    #1;
    check("R9 done one cycle", done == 1'b0, done, 0);
    check("R9 message held", message == heldMsg, message, heldMsg);
  endtask

  task automatic testReset();
    check("R1 done", done == 1'b0, done, 0);
    check("R1 success", success == 1'b0, success, 0);
    check("R1 iterations", superIters == 4'd0, superIters, 0);
    check("R1 message", message == '0, message, 0);
  endtask

  task automatic testClean();
    logic [K-1:0] msgs [3];
    msgs[0] = 16'hA5C3; msgs[1] = 16'h0000; msgs[2] = 16'hFFFF;
    foreach (msgs[n]) expectResult("R4 R7 clean", encode(msgs[n]), -1, 1, 1'b1, 0, msgs[n]);
  endtask

  task automatic testParityErrors();
    logic [3*K-1:0] w;
    w = encode(16'h1234);
    w[2*K + 9] = ~w[2*K + 9];
    expectResult("R7 parity B error", w, -1, 1, 1'b1, 0, 16'h1234);
    w = encode(16'h1234);
    w[K + 4] = ~w[K + 4];
    expectResult("R3 parity A error, interleaved view valid", w, -1, 2, 1'b1, 0, 16'h1234);
  endtask

  task automatic testMessageErrors();
    int pos [3];
    logic [3*K-1:0] w;
    pos[0] = 0; pos[1] = 7; pos[2] = 15;
    foreach (pos[n]) begin
      w = encode(16'hC0DE);
      w[pos[n]] = ~w[pos[n]];
      expectResult("R5 R6 R2 single message error", w, -1, 4, 1'b1, 1, 16'hC0DE);
    end
  endtask

  task automatic testMixedError();
    logic [3*K-1:0] w;
    w = encode(16'h5A69);
    w[6] = ~w[6];
    w[K + 6] = ~w[K + 6];
    expectResult("R2 R3 message+parity A error", w, -1, 5, 1'b1, 1, 16'h5A69);
  endtask

  task automatic testBusyStart();
    logic [3*K-1:0] w;
    w = encode(16'h3C3C);
    w[11] = ~w[11];
    expectResult("R10 start while busy", w, 1, 4, 1'b1, 1, 16'h3C3C);
  endtask

  task automatic testLimit();
    logic [3*K-1:0] w;
    int lat;
    w = encode(16'hBEEF);
    w[3] = ~w[3];
    lat = 0;
    @(negedge clk);
    rxWordS = w;
    startS  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startS = 1'b0;
    while (lat < 200) begin
      @(posedge clk);
      #1;
      lat++;
      if (doneS) break;
    end
    check("R8 limit latency", lat == 3, lat, 3);
    check("R8 limit success", successS == 1'b0, successS, 0);
    check("R8 limit iterations", superItersS == 1'b1, superItersS, 1);
    check("R8 merged message", messageS == 16'hBEEF, messageS, 16'hBEEF);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    @(negedge clk);
    rst = 1'b0;
    testClean();
    testParityErrors();
    testMessageErrors();
    testMixedError();
    testBusyStart();
    testLimit();
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule